// File: doc/BRIEF.md
# DDR SDRAM Self-Refresh Sequencer

This block sits on the controller side of a DDR SDRAM interface. It moves the memory into its self-refresh low-power state and back out again. A request to enter starts the entry sequence. If any bank was activated since the last precharge, the sequencer first closes every bank and waits out the precharge time. It then issues the refresh command in the same cycle that it pulls the clock-enable pin low. While the memory is in self-refresh, clock enable stays low and the sequencer drives a NOP on the command bus.

A request to leave is acted on only when the clock is reported stable. The exit is a single cycle that raises clock enable with a NOP on the bus. From that cycle two separate windows run. A short one, derived from a nanosecond limit, gates every command except reads. A 200-clock one gates reads. The sequencer compares the class of the user's next pending command against these windows and raises a stall when that command may not yet go out.

Cycle counts come from nanosecond parameters divided by the clock period and rounded up. At the default 7.5 ns period, the precharge wait is 3 cycles and the non-read exit window is 10 cycles.

Top module: `selfref_sequencer`

## Requirements
- R1: After synchronous reset, `cke` is 1, `cmd_bus` is NOP (4'b0111, bits {cs_n,ras_n,cas_n,we_n}), both ready outputs are 1 and `stall` is 0.
- R2: With all banks idle, the cycle after `enter_req` is sampled in the idle state shows AUTO REFRESH (4'b0001) with `cke` 0 in that same cycle.
- R3: With a bank open, the cycle after `enter_req` shows PRECHARGE ALL (4'b0010) with `addr_a10` 1 and `cke` 1. NOPs follow, and AUTO REFRESH with `cke` 0 appears exactly TRP_CYC (3) cycles after the precharge.
- R4: A bank counts as open after an `act_issued` pulse in the idle state. It is idle again after a `pre_issued` pulse in the idle state or after the sequencer's own precharge.
- R5: From the cycle after the AUTO REFRESH until exit, `cke` stays 0, `cmd_bus` is NOP, and both ready outputs are 0.
- R6: Exit starts only in self-refresh, and only when an exit request (current or held) is present together with `clk_stable` 1. The exit cycle drives `cke` 1 with NOP.
- R7: An `exit_req` seen during the precharge, wait or refresh cycles is held. The device then spends exactly one cycle in self-refresh before the exit cycle.
- R8: Counting the exit cycle as 0, `ready_nonread` is 0 for cycles below XSNR_CYC (10) and 1 from cycle XSNR_CYC on. `cmd_bus` stays NOP with `cke` 1.
- R9: `ready_read` is 0 for exit cycles below 200 and 1 from cycle 200. After that cycle, the block is idle with both ready outputs at 1.
- R10: `stall` equals `pend_valid` AND NOT the ready output of its class. The class is read when `pend_is_read` is 1 and non-read otherwise.
- R11: `enter_req` outside the idle state and `exit_req` in the idle state or the exit window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Request to enter self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | Memory clock running within specification |
| act_issued | input | 1 | User path activated a row |
| pre_issued | input | 1 | User path precharged all banks |
| pend_valid | input | 1 | A user command is waiting |
| pend_is_read | input | 1 | The waiting command is a read |
| cke | output | 1 | Clock-enable pin |
| cmd_bus | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| addr_a10 | output | 1 | Address bit 10 (all-bank select on precharge) |
| ready_nonread | output | 1 | Non-read commands allowed |
| ready_read | output | 1 | Read commands allowed |
| stall | output | 1 | Waiting command must be held off |

## Verification
The assertions assume that `act_issued` and `pre_issued` are single-cycle pulses given only while the block is idle, and never in the same cycle as `enter_req`. They also assume that `clk_stable` is low only while the device sits in self-refresh. The timing properties take the exit cycle as the only rising edge of `cke`, which holds because nothing else drives it low. The stimulus respects these assumptions. It issues any activate or user precharge a full cycle before an entry request. It draws self-refresh hold times, early exit requests and clock-unstable stretches at random, but it drops `clk_stable` only after the refresh cycle has been observed. Stray enter and exit pulses are injected only in states where they must be ignored.

// File: rtl/selfref_pkg.sv
package selfref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_SR_ENTER,
        ST_SELF,
        ST_EXIT
    } sr_state_e;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_PRE_ALL,
        OP_AUTO_REF
    } seq_op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_NOP      = 4'b0111;
    localparam ddr_cmd_t CMD_PRE_ALL  = 4'b0010;
    localparam ddr_cmd_t CMD_AUTO_REF = 4'b0001;

    // Round a picosecond limit up to whole clock periods.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ps,
                                                 input int unsigned tck_ps);
        return (t_ps + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sr_delay_cnt.sv
module sr_delay_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         count_en,
    output logic [W-1:0] remaining
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (count_en && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign remaining = cnt_q;

endmodule

// File: rtl/sr_bank_track.sv
module sr_bank_track (
    input  logic clk,
    input  logic rst,
    input  logic user_window,
    input  logic act_issued,
    input  logic pre_issued,
    input  logic seq_precharge,
    output logic banks_open
);

    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (seq_precharge || (user_window && pre_issued)) begin
            open_q <= 1'b0;
        end else if (user_window && act_issued) begin
            open_q <= 1'b1;
        end
    end

    assign banks_open = open_q;

endmodule

// File: rtl/sr_cmd_enc.sv
module sr_cmd_enc
    import selfref_pkg::*;
(
    input  seq_op_e    op,
    output logic [3:0] cmd_bus,
    output logic       addr_a10
);

    ddr_cmd_t enc;

    always_comb begin
        unique case (op)
            OP_PRE_ALL:  enc = CMD_PRE_ALL;
            OP_AUTO_REF: enc = CMD_AUTO_REF;
            default:     enc = CMD_NOP;
        endcase
    end

    assign cmd_bus  = enc;
    assign addr_a10 = (op == OP_PRE_ALL);

endmodule

// File: rtl/selfref_sequencer.sv
module selfref_sequencer
    import selfref_pkg::*;
#(
    parameter int unsigned TCK_PS   = 7500,
    parameter int unsigned TRP_PS   = 20000,
    parameter int unsigned TXSNR_PS = 75000,
    parameter int unsigned XSRD_CYC = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enter_req,
    input  logic       exit_req,
    input  logic       clk_stable,
    input  logic       act_issued,
    input  logic       pre_issued,
    input  logic       pend_valid,
    input  logic       pend_is_read,
    output logic       cke,
    output logic [3:0] cmd_bus,
    output logic       addr_a10,
    output logic       ready_nonread,
    output logic       ready_read,
    output logic       stall
);

    localparam int unsigned TRP_CYC  = at_least_one(ns_to_cycles(TRP_PS, TCK_PS));
    localparam int unsigned XSNR_CYC = at_least_one(ns_to_cycles(TXSNR_PS, TCK_PS));
    localparam int unsigned XSRD_N   = at_least_one(XSRD_CYC);
    localparam int unsigned MAX_CYC  = max3(TRP_CYC, XSNR_CYC, XSRD_N);
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);
    localparam int unsigned NWIN     = 2;
    localparam int unsigned WIN_LEN [NWIN] = '{XSNR_CYC, XSRD_N};

    sr_state_e   state_q, state_d;
    logic        exit_pend_q;
    logic        banks_open;
    logic        exit_go;
    logic        exit_start;
    logic        trp_last;
    logic [CW-1:0] trp_left;
    logic [NWIN-1:0] win_done;
    logic [NWIN-1:0] win_ready;
    seq_op_e     op;

    // ---------------- bank state ----------------
    sr_bank_track u_bank (
        .clk          (clk),
        .rst          (rst),
        .user_window  (state_q == ST_IDLE),
        .act_issued   (act_issued),
        .pre_issued   (pre_issued),
        .seq_precharge(state_q == ST_PRE),
        .banks_open   (banks_open)
    );

    // ---------------- precharge wait ----------------
    sr_delay_cnt #(.W(CW)) u_trp (
        .clk      (clk),
        .rst      (rst),
        .load     ((state_q == ST_IDLE) && enter_req && banks_open),
        .load_val (CW'(TRP_CYC)),
        .count_en ((state_q == ST_PRE) || (state_q == ST_WAIT_RP)),
        .remaining(trp_left)
    );

    assign trp_last = (trp_left <= CW'(1));

    // ---------------- exit request handling ----------------
    assign exit_go    = (exit_req || exit_pend_q) && clk_stable;
    assign exit_start = (state_q == ST_SELF) && exit_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            exit_pend_q <= 1'b0;
        end else if (exit_start) begin
            exit_pend_q <= 1'b0;
        end else if (exit_req && ((state_q == ST_PRE) || (state_q == ST_WAIT_RP) ||
                                  (state_q == ST_SR_ENTER) || (state_q == ST_SELF))) begin
            exit_pend_q <= 1'b1;
        end
    end

    // ---------------- state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (enter_req) state_d = banks_open ? ST_PRE : ST_SR_ENTER;
            ST_PRE:      state_d = trp_last ? ST_SR_ENTER : ST_WAIT_RP;
            ST_WAIT_RP:  if (trp_last) state_d = ST_SR_ENTER;
            ST_SR_ENTER: state_d = ST_SELF;
            ST_SELF:     if (exit_go) state_d = ST_EXIT;
            ST_EXIT:     if (win_done[NWIN-1]) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // ---------------- exit permission windows ----------------
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic [CW-1:0] left;

        sr_delay_cnt #(.W(CW)) u_win (
            .clk      (clk),
            .rst      (rst),
            .load     (exit_start),
            .load_val (CW'(WIN_LEN[g])),
            .count_en (state_q == ST_EXIT),
            .remaining(left)
        );

        assign win_done[g]  = (left == '0);
        assign win_ready[g] = (state_q == ST_IDLE) ||
                              ((state_q == ST_EXIT) && win_done[g]);
    end

    // ---------------- pin drive ----------------
    always_comb begin
        unique case (state_q)
            ST_PRE:      op = OP_PRE_ALL;
            ST_SR_ENTER: op = OP_AUTO_REF;
            default:     op = OP_NOP;
        endcase
    end

    sr_cmd_enc u_enc (
        .op      (op),
        .cmd_bus (cmd_bus),
        .addr_a10(addr_a10)
    );

    assign cke           = !((state_q == ST_SR_ENTER) || (state_q == ST_SELF));
    assign ready_nonread = win_ready[0];
    assign ready_read    = win_ready[1];
    assign stall         = pend_valid && (pend_is_read ? !ready_read : !ready_nonread);

endmodule

// File: rtl/selfref_sequencer_chk.sv
module selfref_sequencer_chk
    import selfref_pkg::*;
#(
    parameter int unsigned TCK_PS   = 7500,
    parameter int unsigned TRP_PS   = 20000,
    parameter int unsigned TXSNR_PS = 75000,
    parameter int unsigned XSRD_CYC = 200
) (
    input logic       clk,
    input logic       rst,
    input logic       clk_stable,
    input logic       pend_valid,
    input logic       pend_is_read,
    input logic       cke,
    input logic [3:0] cmd_bus,
    input logic       addr_a10,
    input logic       ready_nonread,
    input logic       ready_read,
    input logic       stall
);

    localparam int unsigned XSNR_CYC = at_least_one(ns_to_cycles(TXSNR_PS, TCK_PS));
    localparam int unsigned XSRD_N   = at_least_one(XSRD_CYC);
    localparam int unsigned SW       = $clog2(XSRD_N + 2);

    // Cycles elapsed with cke high since it last rose; saturating.
    logic [SW-1:0] since_hi;

    always_ff @(posedge clk) begin
        if (rst || !cke)                   since_hi <= '0;
        else if (since_hi != SW'(XSRD_N + 1)) since_hi <= since_hi + 1'b1;
    end

    p_enter_with_ar_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (cmd_bus == CMD_AUTO_REF));

    p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_bus == CMD_PRE_ALL) |-> (addr_a10 && cke));

    p_sr_bus_nop_r5: assert property (@(posedge clk) disable iff (rst)
        (!cke && $past(!cke)) |-> (cmd_bus == CMD_NOP));

    p_sr_not_ready_r5: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (!ready_nonread && !ready_read));

    p_exit_clock_ok_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> ($past(clk_stable) && (cmd_bus == CMD_NOP)));

    p_nonread_window_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_nonread) |-> (since_hi == SW'(XSNR_CYC)));

    p_read_window_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_read) |-> (since_hi == SW'(XSRD_N)));

    p_read_after_nonread_r9: assert property (@(posedge clk) disable iff (rst)
        ready_read |-> ready_nonread);

    p_stall_class_r10: assert property (@(posedge clk) disable iff (rst)
        (stall && pend_is_read) |-> (pend_valid && !ready_read));

endmodule

bind selfref_sequencer selfref_sequencer_chk #(
    .TCK_PS  (TCK_PS),
    .TRP_PS  (TRP_PS),
    .TXSNR_PS(TXSNR_PS),
    .XSRD_CYC(XSRD_CYC)
) u_chk (.*);

// File: tb/test_selfref_sequencer.sv
module test_selfref_sequencer;

    localparam int TCK_PS   = 7500;
    localparam int TRP_PS   = 20000;
    localparam int TXSNR_PS = 75000;
    localparam int XSRD     = 200;

    function automatic int to_cyc(input int t_ps);
        return (t_ps + TCK_PS - 1) / TCK_PS;
    endfunction

    localparam int TRP_N  = to_cyc(TRP_PS);
    localparam int XSNR_N = to_cyc(TXSNR_PS);

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] AR  = 4'b0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enter_req = 0, exit_req = 0, clk_stable = 1;
    logic act_issued = 0, pre_issued = 0, pend_valid = 0, pend_is_read = 0;
    logic cke, addr_a10, ready_nonread, ready_read, stall;
    logic [3:0] cmd_bus;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    selfref_sequencer i_selfref_sequencer (
        .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
        .clk_stable(clk_stable), .act_issued(act_issued), .pre_issued(pre_issued),
        .pend_valid(pend_valid), .pend_is_read(pend_is_read), .cke(cke),
        .cmd_bus(cmd_bus), .addr_a10(addr_a10), .ready_nonread(ready_nonread),
        .ready_read(ready_read), .stall(stall)
    );

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check_bus(input string req, input logic [3:0] exp_cmd, input bit exp_cke);
        chk_eq(req, "cke", int'(cke), int'(exp_cke));
        chk_eq(req, "cmd_bus", int'(cmd_bus), int'(exp_cmd));
    endtask

    // R10: drive a random pending command and compare stall with its class.
    task automatic check_ready(input string req, input bit exp_nr, input bit exp_rd);
        bit pv, pr, exp_stall;
        chk_eq(req, "ready_nonread", int'(ready_nonread), int'(exp_nr));
        chk_eq(req, "ready_read", int'(ready_read), int'(exp_rd));
        pv = 1'($urandom % 2);
        pr = 1'($urandom % 2);
        pend_valid   = pv;
        pend_is_read = pr;
        #1;
        exp_stall = pv && (pr ? !exp_rd : !exp_nr);
        chk_eq("R10", "stall", int'(stall), int'(exp_stall));
    endtask

    // One full entry / hold / exit round trip.
    task automatic round_trip(input bit open, input bit user_pre, input bit early,
                              input int hold, input bit unstable);
        bit eff_open;
        eff_open = open && !user_pre;
        if (open) begin act_issued = 1; tick(); act_issued = 0; end
        if (user_pre) begin pre_issued = 1; tick(); pre_issued = 0; end
        enter_req = 1; tick(); enter_req = 0;
        if (early) exit_req = 1;
        if (eff_open) begin
            check_bus("R3", PRE, 1);
            chk_eq("R3", "a10", int'(addr_a10), 1);
            for (int k = 1; k < TRP_N; k++) begin
                tick(); exit_req = 0;
                check_bus("R3", NOP, 1);
            end
            tick(); exit_req = 0;
            check_bus("R3", AR, 0);
        end else begin
            check_bus(open ? "R4" : "R2", AR, 0);
        end
        check_ready("R5", 0, 0);
        tick(); exit_req = 0;
        check_bus("R5", NOP, 0);
        check_ready("R5", 0, 0);
        if (early) begin
            tick();
            check_bus("R7", NOP, 1);
        end else begin
            for (int i = 0; i < hold; i++) begin
                enter_req = 1'($urandom % 2);
                tick();
                check_bus("R11", NOP, 0);
                check_ready("R5", 0, 0);
            end
            enter_req = 0;
            if (unstable) begin
                clk_stable = 0; exit_req = 1;
                tick(); exit_req = 0;
                check_bus("R6", NOP, 0);
                for (int i = 0; i < 3; i++) begin
                    tick();
                    check_bus("R6", NOP, 0);
                end
                clk_stable = 1;
            end else begin
                exit_req = 1;
            end
            tick(); exit_req = 0;
            check_bus("R6", NOP, 1);
        end
        for (int k = 0; k <= XSRD; k++) begin
            if (k > 0) tick();
            check_bus("R8", NOP, 1);
            check_ready((k >= XSNR_N) ? "R9" : "R8", k >= XSNR_N, k >= XSRD);
            if (k < XSRD) begin
                enter_req = 1'($urandom % 2);
                exit_req  = 1'($urandom % 2);
            end else begin
                enter_req = 0; exit_req = 0;
            end
        end
        tick();
        check_bus("R9", NOP, 1);
        check_ready("R9", 1, 1);
        exit_req = 1; tick(); exit_req = 0;
        check_bus("R11", NOP, 1);
        check_ready("R11", 1, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst = 0;
        tick();
        check_bus("R1", NOP, 1);
        check_ready("R1", 1, 1);
        pend_valid = 0;
        #1 chk_eq("R1", "stall", int'(stall), 0);

        round_trip(0, 0, 0, 3, 0);
        round_trip(1, 0, 0, 2, 0);
        round_trip(0, 0, 0, 1, 0);   // sequencer precharge left banks idle (R4)
        round_trip(1, 1, 0, 2, 0);   // user precharge closes banks (R4)
        round_trip(1, 0, 1, 0, 0);   // early exit with precharge (R7)
        round_trip(0, 0, 1, 0, 0);   // early exit without precharge (R7)
        round_trip(0, 0, 0, 4, 1);   // clock not yet stable (R6)
        for (int n = 0; n < 20; n++) begin
            bit o, up, e, u;
            o  = 1'($urandom % 2);
            up = o && (($urandom % 4) == 0);
            e  = 1'($urandom % 3 == 0);
            u  = !e && (($urandom % 3) == 0);
            round_trip(o, up, e, int'($urandom % 8), u);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule